// File: doc/BRIEF.md
# VFD Grid Scan, Blink and Dimmer Timer

This block produces the multiplex timing for a dot-matrix vacuum fluorescent display with 1 to 16 digit positions. It walks a single active grid line through the programmed number of digits. Each digit gets a fixed-length slot. Inside the slot, an anode enable window opens after a short blanking gap, and its width follows an 8-bit brightness value. The main dot anodes and the auxiliary anodes are gated by a global display switch, by per-digit enable masks and by per-digit blink masks. The main and auxiliary data have separate enable and blink selects.

The block reports the index of the digit it is scanning. The surrounding logic uses that index to supply the main dot pattern and the auxiliary bits for that digit, combinationally. Configuration values come straight from the command decoder and are sampled every clock. When 12 or more digits are in use, five of the eight auxiliary anode pins are turned into the grid lines for digits 12 to 16. All pin outputs are registered.

Top module: `vfd_scan_timer`

## Requirements
- R1: The grid outputs are one-hot or all zero. Digits are scanned in ascending order 1, 2, ... N and then wrap to digit 1. Each digit occupies a slot of BLANK_CLKS + DUTY_STEPS clocks (256 by default). `digit_o` gives the zero-based index of the digit being scanned.
- R2: The digit count N comes from `grid_code`: code 0 gives 16 digits, and a code k from 1 to 15 gives k digits. With N = 1, grid line 1 stays continuously active.
- R3: Within a slot, the anode window starts BLANK_CLKS clocks (16 by default) after the grid line rises and lasts `duty` clocks. A duty value of 0 lights no anode.
- R4: Duty values of DUTY_STEPS (240) and above give a window of exactly DUTY_STEPS clocks.
- R5: A digit's grid line is driven only when `disp_on` is 1, the digit's bit in `on_mask` is 1 (bit 0 is digit 1), and at least one of `on_main` or `on_aux` is 1. Main anodes follow `main_dots` only if `on_main` is 1. Auxiliary anodes follow `aux_dots` only if `on_aux` is 1.
- R6: While `disp_on` is 0, and from reset onward until the display is switched on, every grid, main anode and auxiliary pin is 0.
- R7: When blinking is active, a digit whose `blink_mask` bit is 1 has its selected data blanked during alternate blink phases. Main data is selected by `blink_main` and auxiliary data by `blink_aux`. Digits with a 0 mask bit, and data types that are not selected, stay lit. `blink_code` 0 stops blinking.
- R8: The blink phase toggles every BLINK_UNIT × m clocks, where m is 1, 2, 3, 4, 5, 8 or 10 for `blink_code` 1 to 7 respectively.
- R9: Auxiliary bit k of `aux_dots` drives `aux_o[k]` directly during the anode window, with no lookup.
- R10: When N ≥ 12 (codes 0, 12 to 15), `aux_o[7]`, `aux_o[6]`, `aux_o[5]`, `aux_o[4]` and `aux_o[3]` act as the grid lines of digits 12, 13, 14, 15 and 16 respectively. Only `aux_o[2:0]` then carry auxiliary anode data. For N ≤ 11, all eight are anodes.
- R11: A blink phase change takes effect only at a slot boundary, so every lit slot carries its full anode window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grid_code | input | 4 | Digit count code (0 = 16 digits) |
| duty | input | 8 | Anode window width in clocks, clamped at 240 |
| disp_on | input | 1 | Global display switch |
| on_main | input | 1 | Main dot data enable |
| on_aux | input | 1 | Auxiliary data enable |
| on_mask | input | 16 | Per-digit enable, bit 0 = digit 1 |
| blink_code | input | 3 | Blink period select, 0 = no blinking |
| blink_main | input | 1 | Blink applies to main data |
| blink_aux | input | 1 | Blink applies to auxiliary data |
| blink_mask | input | 16 | Per-digit blink select, bit 0 = digit 1 |
| main_dots | input | 35 | Dot pattern of the digit named by `digit_o` |
| aux_dots | input | 8 | Auxiliary bits of the digit named by `digit_o` |
| digit_o | output | 4 | Zero-based index of the digit being scanned |
| grid_o | output | 11 | Grid lines of digits 1 to 11 |
| anode_o | output | 35 | Main dot anodes |
| aux_o | output | 8 | Auxiliary anodes; bits 7..3 double as grids 12..16 |

## Verification
The assertions assume that `main_dots` and `aux_dots` follow `digit_o` within the same cycle. They also assume that configuration inputs that change in one cycle are reflected on the pins in the next cycle only, so every property about the outputs looks one clock after the input it depends on. The stimulus changes the configuration only on the inactive clock edge. It then waits a full slot before measuring, so a slot that straddles a reconfiguration is never scored. The per-digit data is a fixed function of the digit index, which lets each observed slot be attributed to a digit. All enable masks are kept full during the slot-by-slot scoring, so that no grid pulse is missing from the sequence.

// File: rtl/vfd_scan_pkg.sv
package vfd_scan_pkg;

  localparam int CODE_W    = 4;
  localparam int DIG_W     = 4;
  localparam int MAX_DIGS  = 16;
  localparam int AUX_PINS  = 8;
  localparam int AUX_FIXED = 3;   // aux pins that never become grids
  localparam int DED_GRIDS = 11;  // dedicated grid pins
  localparam int BCODE_W   = 3;

  // number of scanned digits for a grid count code (0 means all sixteen)
  function automatic logic [DIG_W:0] digit_count(input logic [CODE_W-1:0] code);
    return (code == '0) ? (DIG_W+1)'(MAX_DIGS) : {1'b0, code};
  endfunction

  // true when the shared aux pins are needed as grid lines
  function automatic logic shared_as_grid(input logic [CODE_W-1:0] code);
    return (code == '0) || (code >= CODE_W'(DED_GRIDS + 1));
  endfunction

  // blink interval multiple of the base unit for each period code
  function automatic int unsigned blink_mult(input logic [BCODE_W-1:0] code);
    case (code)
      3'd1:    return 1;
      3'd2:    return 2;
      3'd3:    return 3;
      3'd4:    return 4;
      3'd5:    return 5;
      3'd6:    return 8;
      3'd7:    return 10;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/vfd_slot_timer.sv
module vfd_slot_timer
  import vfd_scan_pkg::*;
#(
  parameter int BLANK_CLKS = 16,
  parameter int DUTY_STEPS = 240,
  parameter int DUTY_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] grid_code,
  input  logic [DUTY_W-1:0] duty,
  output logic [DIG_W-1:0]  digit_o,
  output logic              slot_end_o,
  output logic              window_o
);

  localparam int SLOT_CLKS = BLANK_CLKS + DUTY_STEPS;
  localparam int CW        = $clog2(SLOT_CLKS + 1);

  logic [CW-1:0]    cnt_q, cnt_d;
  logic [DIG_W-1:0] dig_q, dig_d;
  logic [DIG_W:0]   n_digs;
  logic [CW:0]      duty_ext, lim, offs;
  logic             slot_end;

  always_comb begin
    slot_end = (cnt_q == CW'(SLOT_CLKS - 1));
    cnt_d    = slot_end ? '0 : cnt_q + 1'b1;
    n_digs   = digit_count(grid_code);
    dig_d    = dig_q;
    if (slot_end) begin
      if (({1'b0, dig_q} + 1'b1) >= n_digs) dig_d = '0;
      else                                   dig_d = dig_q + 1'b1;
    end
  end

  // anode window: clamp the duty, then open after the blanking gap
  always_comb begin
    duty_ext = (CW+1)'(duty);
    lim      = (duty_ext >= (CW+1)'(DUTY_STEPS)) ? (CW+1)'(DUTY_STEPS) : duty_ext;
    offs     = {1'b0, cnt_q} - (CW+1)'(BLANK_CLKS);
    window_o = ({1'b0, cnt_q} >= (CW+1)'(BLANK_CLKS)) && (offs < lim);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dig_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      dig_q <= dig_d;
    end
  end

  assign digit_o    = dig_q;
  assign slot_end_o = slot_end;

endmodule

// File: rtl/vfd_blink_gen.sv
module vfd_blink_gen
  import vfd_scan_pkg::*;
#(
  parameter int BLINK_UNIT = 1000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [BCODE_W-1:0] blink_code,
  input  logic               slot_end,
  output logic               phase_o
);

  localparam int MAX_CNT = BLINK_UNIT * 10;
  localparam int CW      = $clog2(MAX_CNT + 1);

  logic [CW-1:0] cnt_q, cnt_d, limit;
  logic          ph_q, ph_d;
  logic          slot_ph_q, slot_ph_d;

  always_comb begin
    limit = CW'(BLINK_UNIT * blink_mult(blink_code));
    cnt_d = cnt_q;
    ph_d  = ph_q;
    if (blink_code == '0) begin
      cnt_d = '0;
      ph_d  = 1'b0;
    end else if (cnt_q >= limit - 1'b1) begin
      cnt_d = '0;
      ph_d  = ~ph_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
    // the slot-level phase is only refreshed on a slot boundary
    slot_ph_d = slot_end ? ph_q : slot_ph_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      ph_q      <= 1'b0;
      slot_ph_q <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      ph_q      <= ph_d;
      slot_ph_q <= slot_ph_d;
    end
  end

  assign phase_o = slot_ph_q;

endmodule

// File: rtl/vfd_pin_mux.sv
module vfd_pin_mux
  import vfd_scan_pkg::*;
#(
  parameter int MAIN_W = 35
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DIG_W-1:0]     digit,
  input  logic                 window,
  input  logic                 blink_phase,
  input  logic [CODE_W-1:0]    grid_code,
  input  logic                 disp_on,
  input  logic                 on_main,
  input  logic                 on_aux,
  input  logic [MAX_DIGS-1:0]  on_mask,
  input  logic                 blink_main,
  input  logic                 blink_aux,
  input  logic [MAX_DIGS-1:0]  blink_mask,
  input  logic [MAIN_W-1:0]    main_dots,
  input  logic [AUX_PINS-1:0]  aux_dots,
  output logic [DED_GRIDS-1:0] grid_o,
  output logic [MAIN_W-1:0]    anode_o,
  output logic [AUX_PINS-1:0]  aux_o
);

  logic                 dig_en, blink_now, main_vis, aux_vis, share;
  logic [MAX_DIGS-1:0]  grid_1h;
  logic [MAIN_W-1:0]    main_d;
  logic [AUX_PINS-1:0]  aux_anode, aux_d;

  always_comb begin
    dig_en    = disp_on && on_mask[digit];
    blink_now = blink_phase && blink_mask[digit];
    main_vis  = dig_en && on_main && !(blink_now && blink_main);
    aux_vis   = dig_en && on_aux  && !(blink_now && blink_aux);
    grid_1h   = (dig_en && (on_main || on_aux)) ? (MAX_DIGS'(1) << digit) : '0;
    main_d    = (main_vis && window) ? main_dots : '0;
    aux_anode = (aux_vis  && window) ? aux_dots  : '0;
    share     = shared_as_grid(grid_code);
  end

  // aux pins: low ones always anodes, high ones become grids 12..16 in reverse order
  for (genvar k = 0; k < AUX_PINS; k++) begin : g_aux
    if (k < AUX_FIXED) begin : g_fixed
      assign aux_d[k] = aux_anode[k];
    end else begin : g_shared
      localparam int GBIT = DED_GRIDS + (AUX_PINS - 1 - k);
      assign aux_d[k] = share ? grid_1h[GBIT] : aux_anode[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grid_o  <= '0;
      anode_o <= '0;
      aux_o   <= '0;
    end else begin
      grid_o  <= grid_1h[DED_GRIDS-1:0];
      anode_o <= main_d;
      aux_o   <= aux_d;
    end
  end

endmodule

// File: rtl/vfd_scan_timer.sv
module vfd_scan_timer
  import vfd_scan_pkg::*;
#(
  parameter int BLANK_CLKS = 16,
  parameter int DUTY_STEPS = 240,
  parameter int DUTY_W     = 8,
  parameter int BLINK_UNIT = 1000,
  parameter int MAIN_W     = 35
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CODE_W-1:0]    grid_code,
  input  logic [DUTY_W-1:0]    duty,
  input  logic                 disp_on,
  input  logic                 on_main,
  input  logic                 on_aux,
  input  logic [MAX_DIGS-1:0]  on_mask,
  input  logic [BCODE_W-1:0]   blink_code,
  input  logic                 blink_main,
  input  logic                 blink_aux,
  input  logic [MAX_DIGS-1:0]  blink_mask,
  input  logic [MAIN_W-1:0]    main_dots,
  input  logic [AUX_PINS-1:0]  aux_dots,
  output logic [DIG_W-1:0]     digit_o,
  output logic [DED_GRIDS-1:0] grid_o,
  output logic [MAIN_W-1:0]    anode_o,
  output logic [AUX_PINS-1:0]  aux_o
);

  logic slot_end, window, blink_phase;

  vfd_slot_timer #(
    .BLANK_CLKS (BLANK_CLKS),
    .DUTY_STEPS (DUTY_STEPS),
    .DUTY_W     (DUTY_W)
  ) u_slot (
    .clk        (clk),
    .rst_n      (rst_n),
    .grid_code  (grid_code),
    .duty       (duty),
    .digit_o    (digit_o),
    .slot_end_o (slot_end),
    .window_o   (window)
  );

  vfd_blink_gen #(
    .BLINK_UNIT (BLINK_UNIT)
  ) u_blink (
    .clk        (clk),
    .rst_n      (rst_n),
    .blink_code (blink_code),
    .slot_end   (slot_end),
    .phase_o    (blink_phase)
  );

  vfd_pin_mux #(
    .MAIN_W (MAIN_W)
  ) u_mux (
    .clk         (clk),
    .rst_n       (rst_n),
    .digit       (digit_o),
    .window      (window),
    .blink_phase (blink_phase),
    .grid_code   (grid_code),
    .disp_on     (disp_on),
    .on_main     (on_main),
    .on_aux      (on_aux),
    .on_mask     (on_mask),
    .blink_main  (blink_main),
    .blink_aux   (blink_aux),
    .blink_mask  (blink_mask),
    .main_dots   (main_dots),
    .aux_dots    (aux_dots),
    .grid_o      (grid_o),
    .anode_o     (anode_o),
    .aux_o       (aux_o)
  );

endmodule

// File: rtl/vfd_scan_checker.sv
module vfd_scan_checker
  import vfd_scan_pkg::*;
#(
  parameter int DUTY_W = 8,
  parameter int MAIN_W = 35
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [DUTY_W-1:0]    duty,
  input logic                 disp_on,
  input logic [MAX_DIGS-1:0]  on_mask,
  input logic [DIG_W-1:0]     digit_o,
  input logic [DED_GRIDS-1:0] grid_o,
  input logic [MAIN_W-1:0]    anode_o,
  input logic [AUX_PINS-1:0]  aux_o
);

  AST_GRID_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grid_o)); // R1

  AST_DIGIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (digit_o != $past(digit_o)) |-> (digit_o == $past(digit_o) + 4'd1 || digit_o == '0)); // R1

  AST_DARK_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_on |=> (grid_o == '0 && anode_o == '0 && aux_o == '0)); // R6

  AST_ZERO_DUTY_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (duty == '0) |=> (anode_o == '0 && aux_o[AUX_FIXED-1:0] == '0)); // R3

  AST_MASKED_DIGIT_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_on && !on_mask[digit_o]) |=> (grid_o == '0 && anode_o == '0 && aux_o == '0)); // R5

  AST_ANODE_NEEDS_GRID: assert property (@(posedge clk) disable iff (!rst_n)
    (|anode_o) |-> ((|grid_o) || (|aux_o[AUX_PINS-1:AUX_FIXED]))); // R5

endmodule

bind vfd_scan_timer vfd_scan_checker #(
  .DUTY_W (DUTY_W),
  .MAIN_W (MAIN_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .duty    (duty),
  .disp_on (disp_on),
  .on_mask (on_mask),
  .digit_o (digit_o),
  .grid_o  (grid_o),
  .anode_o (anode_o),
  .aux_o   (aux_o)
);

// File: tb/sim_vfd_scan_timer.sv
module sim_vfd_scan_timer;

  localparam int CLK_PERIOD = 10;
  localparam int BLANK      = 16;
  localparam int STEPS      = 240;
  localparam int SLOT       = BLANK + STEPS;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  grid_code;
  logic [7:0]  duty;
  logic        disp_on, on_main, on_aux, blink_main, blink_aux;
  logic [15:0] on_mask, blink_mask;
  logic [2:0]  blink_code;
  logic [34:0] main_dots;
  logic [7:0]  aux_dots;
  logic [3:0]  digit_o;
  logic [10:0] grid_o;
  logic [34:0] anode_o;
  logic [7:0]  aux_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [34:0] pat_main(input logic [3:0] d);
    return 35'h5_2A3C_0001 ^ {d, d, d, d, d, d, d, d, 3'b000};
  endfunction

  function automatic logic [7:0] pat_aux(input logic [3:0] d);
    return {d, 4'b0101};
  endfunction

  assign main_dots = pat_main(digit_o);
  assign aux_dots  = pat_aux(digit_o);

  vfd_scan_timer u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .grid_code  (grid_code),
    .duty       (duty),
    .disp_on    (disp_on),
    .on_main    (on_main),
    .on_aux     (on_aux),
    .on_mask    (on_mask),
    .blink_code (blink_code),
    .blink_main (blink_main),
    .blink_aux  (blink_aux),
    .blink_mask (blink_mask),
    .main_dots  (main_dots),
    .aux_dots   (aux_dots),
    .digit_o    (digit_o),
    .grid_o     (grid_o),
    .anode_o    (anode_o),
    .aux_o      (aux_o)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input bit ok, input string msg);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s", msg);
    end
  endtask

  // ---------------- scoreboard ----------------
  typedef struct {
    logic [15:0] g;
    int          w;
    logic [34:0] mp;
    logic [7:0]  ap;
    string       tag;
  } exp_t;

  exp_t        exp_q[$];
  exp_t        e;
  bit          many_b = 1'b0;
  bit          in_slot = 1'b0;
  logic [15:0] gv, prev_gv = '0, cur_g;
  logic [7:0]  amask;
  logic [34:0] mseen;
  logic [7:0]  aseen;
  int          cyc, wid, offs;

  always @(negedge clk) begin
    gv    = {many_b ? {aux_o[3], aux_o[4], aux_o[5], aux_o[6], aux_o[7]} : 5'b0, grid_o};
    amask = many_b ? 8'h07 : 8'hFF;
    if (in_slot && gv != cur_g) begin
      e = exp_q.pop_front();
      check((cur_g == e.g) && (wid == e.w) && (mseen == e.mp) && (aseen == e.ap) &&
            (cyc == SLOT) && (e.w == 0 || offs == BLANK),
            $sformatf("%s slot: grid %h exp %h, width %0d exp %0d, start %0d exp %0d, len %0d exp %0d, main %h exp %h, aux %h exp %h",
                      e.tag, cur_g, e.g, wid, e.w, offs, BLANK, cyc, SLOT, mseen, e.mp, aseen, e.ap));
      in_slot = 1'b0;
      if (exp_q.size() != 0 && gv != '0) begin
        in_slot = 1'b1; cur_g = gv; cyc = 0; wid = 0; offs = -1; mseen = '0; aseen = '0;
      end
    end else if (!in_slot && exp_q.size() != 0 && gv == 16'h0001 && prev_gv != 16'h0001) begin
      in_slot = 1'b1; cur_g = gv; cyc = 0; wid = 0; offs = -1; mseen = '0; aseen = '0;
    end
    if (in_slot) begin
      if (anode_o != '0) begin
        if (offs < 0) offs = cyc;
        wid++;
        mseen |= anode_o;
      end
      aseen |= aux_o & amask;
      cyc++;
    end
    prev_gv = gv;
  end

  task automatic set_cfg(input logic [3:0] code, input logic [7:0] dt,
                         input bit m, input bit a);
    @(negedge clk);
    grid_code = code; duty = dt; on_main = m; on_aux = a;
    many_b    = (code == 4'd0) || (code >= 4'd12);
    repeat (SLOT + 2) @(negedge clk);
  endtask

  // driver: push one expected item per digit of a frame, then wait for the monitor
  task automatic run_frame(input string tag);
    int   n  = (grid_code == 4'd0) ? 16 : int'(grid_code);
    int   ew = (duty >= 8'd240) ? 240 : int'(duty);
    exp_t x;
    for (int d = 0; d < n; d++) begin
      x.g   = 16'h0001 << d;
      x.w   = on_main ? ew : 0;
      x.mp  = (on_main && ew > 0) ? pat_main(4'(d)) : '0;
      x.ap  = (on_aux && ew > 0) ? (pat_aux(4'(d)) & (many_b ? 8'h07 : 8'hFF)) : '0;
      x.tag = tag;
      exp_q.push_back(x);
    end
    while (exp_q.size() != 0 || in_slot) @(negedge clk);
  endtask

  // blink measurement over successive digit-1 slots
  task automatic measure(input int visits, output int dark, output int chg,
                         output int adark, output int badw);
    int v = 0; bit prev = 0; bit ins = 0; int w = 0; bit a = 0;
    dark = 0; chg = 0; adark = 0; badw = 0;
    while (grid_o[0]) @(negedge clk);
    while (v < visits) begin
      @(negedge clk);
      if (grid_o[0]) begin
        if (!ins) begin ins = 1; w = 0; a = 0; end
        if (anode_o != '0) w++;
        if (aux_o[2:0] != '0) a = 1;
      end else if (ins) begin
        ins = 0;
        if (w == 0) dark++;
        else if (w != 200) badw++;
        if (!a) adark++;
        if (v > 0 && ((w > 0) != prev)) chg++;
        prev = (w > 0);
        v++;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int bad_cnt; int dark, chg, adark, badw;
    logic [10:0] seen;
    rst_n = 1'b0; grid_code = 4'd8; duty = 8'd0; disp_on = 1'b0;
    on_main = 1'b1; on_aux = 1'b1; on_mask = 16'hFFFF;
    blink_code = 3'd0; blink_main = 1'b0; blink_aux = 1'b0; blink_mask = 16'h0000;

    // R6: dark in and after reset while the display is still off
    bad_cnt = 0;
    repeat (5) begin
      @(negedge clk);
      if (grid_o != '0 || anode_o != '0 || aux_o != '0) bad_cnt++;
    end
    rst_n = 1'b1;
    repeat (20) begin
      @(negedge clk);
      if (grid_o != '0 || anode_o != '0 || aux_o != '0) bad_cnt++;
    end
    check(bad_cnt == 0, $sformatf("R6 reset: lit cycles %0d exp 0", bad_cnt));

    // R6: display switch off with everything else enabled
    duty = 8'd200; grid_code = 4'd4;
    bad_cnt = 0;
    repeat (1100) begin
      @(negedge clk);
      if (grid_o != '0 || anode_o != '0 || aux_o != '0) bad_cnt++;
    end
    check(bad_cnt == 0, $sformatf("R6 display off: lit cycles %0d exp 0", bad_cnt));

    @(negedge clk); disp_on = 1'b1;

    // scoreboard frames
    set_cfg(4'd8, 8'd255, 1'b1, 1'b1);  run_frame("R1 R4 R9 (8 digits, duty clamp)");
    set_cfg(4'd8, 8'd100, 1'b1, 1'b1);  run_frame("R1 R3 (8 digits, duty 100)");
    set_cfg(4'd0, 8'd50,  1'b1, 1'b1);  run_frame("R2 R10 (16 digits)");
    set_cfg(4'd12, 8'd240, 1'b1, 1'b1); run_frame("R10 R4 (12 digits, duty 240)");
    set_cfg(4'd5, 8'd0,   1'b1, 1'b1);  run_frame("R3 (duty 0)");
    set_cfg(4'd3, 8'd77,  1'b0, 1'b1);  run_frame("R5 (aux only)");

    // R5: a masked digit never gets its grid or anodes
    set_cfg(4'd4, 8'd200, 1'b1, 1'b1);
    on_mask = 16'hFFFB;
    @(negedge clk);
    seen = '0; bad_cnt = 0;
    repeat (1100) begin
      @(negedge clk);
      seen |= grid_o;
      if (grid_o == '0 && (anode_o != '0 || aux_o != '0)) bad_cnt++;
    end
    check(seen == 11'h00B && bad_cnt == 0,
          $sformatf("R5 mask: grids seen %h exp 00b, stray anode cycles %0d exp 0", seen, bad_cnt));
    on_mask = 16'hFFFF;

    // R2: a single digit keeps grid 1 active continuously
    set_cfg(4'd1, 8'd200, 1'b1, 1'b1);
    bad_cnt = 0;
    repeat (600) begin
      @(negedge clk);
      if (grid_o != 11'h001) bad_cnt++;
    end
    check(bad_cnt == 0, $sformatf("R2 one digit: cycles off grid 1 %0d exp 0", bad_cnt));

    // blink tests with two digits, digit 1 selected
    set_cfg(4'd2, 8'd200, 1'b1, 1'b1);
    blink_mask = 16'h0001; blink_main = 1'b1; blink_aux = 1'b0;
    blink_code = 3'd0;
    repeat (2 * SLOT) @(negedge clk);
    measure(32, dark, chg, adark, badw);
    check(dark == 0, $sformatf("R7 blink code 0: dark slots %0d exp 0", dark));

    blink_code = 3'd1;
    repeat (2 * SLOT) @(negedge clk);
    measure(32, dark, chg, adark, badw);
    check(dark >= 10 && dark <= 22, $sformatf("R7 blink main: dark slots %0d exp 10..22", dark));
    check(chg >= 8, $sformatf("R8 code 1: phase changes %0d exp >= 8", chg));
    check(badw == 0, $sformatf("R11 partial windows %0d exp 0", badw));

    blink_code = 3'd6;
    repeat (2 * SLOT) @(negedge clk);
    measure(32, dark, chg, adark, badw);
    check(chg >= 1 && chg <= 4, $sformatf("R8 code 6: phase changes %0d exp 1..4", chg));
    check(badw == 0, $sformatf("R11 partial windows code 6 %0d exp 0", badw));

    blink_code = 3'd1; blink_mask = 16'h0002;
    repeat (2 * SLOT) @(negedge clk);
    measure(32, dark, chg, adark, badw);
    check(dark == 0, $sformatf("R7 unmasked digit: dark slots %0d exp 0", dark));

    blink_mask = 16'h0001; blink_main = 1'b0; blink_aux = 1'b1;
    repeat (2 * SLOT) @(negedge clk);
    measure(32, dark, chg, adark, badw);
    check(dark == 0 && adark >= 10 && adark <= 22,
          $sformatf("R7 blink aux only: main dark %0d exp 0, aux dark %0d exp 10..22", dark, adark));

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule